// File: doc/BRIEF.md
# Linked-Descriptor Chain DMA Channel

This block is the control core of a single DMA channel. Software writes the address of a first descriptor into the channel and sets a start bit. The channel then reads a 32-byte descriptor from memory. The descriptor gives a source address, a destination address, a byte count and a link word. The channel copies the payload one 32-bit word at a time: it reads a word from the source, then writes it to the destination. When a descriptor is finished, the channel either follows the link word to the next descriptor or stops, if the link word carries the end-of-chain flag.

The channel uses one memory port with a request/acknowledge handshake. The port carries descriptor fetches as well as payload reads and writes. A small word-indexed register port gives software the mode, the status, the current and next descriptor, the remaining byte count and the two attribute words. The attribute words are latched from the descriptor but have no effect on the transfer. Status events are sticky, and writing ones to them clears them. A level interrupt is raised while any enabled event is pending.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset the mode, status and current-descriptor registers read zero, `irq` is low and `mem_req` is low.
- R2: Writing the mode register (index 0) with bit 0 (start) set and bit 1 (abort) clear while the channel is not busy starts the channel. Status bit 0 (busy) sets, status bit 1 (halted) clears, and the eight descriptor words are read in order from current, current+4, up to current+28.
- R3: Descriptor word offsets are fixed: 0 source attribute, 1 source address, 2 destination attribute, 3 destination address, 4 unused, 5 link word, 6 unused, 7 byte count. The attribute words read back at register indices 5 and 6 and do not change any address the channel drives.
- R4: For a count of N bytes the channel copies N/4 words (the low two count bits are ignored). Each word is read from source+4k and then written to destination+4k. The remaining-count register (index 4) reads zero after a descriptor completes.
- R5: In the link word, bit 0 is end-of-chain and bit 3 enables the end-of-segment event. The next-descriptor register (index 3) shows the raw link word. When bit 0 is clear, the link word with its low five bits cleared is loaded into the current-descriptor register (index 2) and fetched next.
- R6: When a descriptor whose link bit 3 is set completes, status bit 2 sets. A completed descriptor with link bit 0 set sets status bit 3 and halted, clears busy and clears the mode start bit, and the current-descriptor register keeps that descriptor's address.
- R7: A descriptor whose count is below 4 sets status bit 4 (programming error), leaves the remaining count at zero, performs no payload access and halts the channel.
- R8: An acknowledge with `mem_err` high sets status bit 5 (transfer error), halts the channel, and the erroneous write does not complete.
- R9: Writing mode bit 1 while busy stops the channel at the next memory boundary. Halted sets, busy clears, no further requests are issued, both mode bits read zero, and no end-of-chain event is raised.
- R10: Writing ones to status bits 2 to 5 clears them. Zero bits leave them unchanged, and busy and halted cannot be written.
- R11: `irq` is high exactly while (mode bit 4 and status bit 4 or 5) or (mode bit 5 and status bit 2) or (mode bit 6 and status bit 3).
- R12: The current-descriptor register stores a written value with its low five bits cleared. A write to it is ignored while the channel is busy.
- R13: Once `mem_req` is raised, it stays high with a stable address, direction and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on index) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory access complete |
| mem_err | input | 1 | Memory access failed (with acknowledge) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach from the ports are an abort or a bus error landing in the middle of a long payload copy, with a request already outstanding. To reach them, the bench runs a long descriptor against a memory model that stalls for a random 0 to 2 cycles on each access. It then writes the abort bit part-way through the copy, or it arms the model to fail one chosen source address, so that the error falls after exactly two words have been written. Randomly sized chains with random segment flags, random garbage in the low count bits and random interrupt enables check the link walk and the interrupt gating together.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int WORD_W      = 32;
    localparam int BYTE_SHIFT  = $clog2(WORD_W / 8);
    localparam int DESC_WORDS  = 8;
    localparam int DESC_IDX_W  = $clog2(DESC_WORDS);
    localparam int ALIGN_BITS  = $clog2(DESC_WORDS * WORD_W / 8);
    localparam int REG_AW      = 3;

    // descriptor word offsets
    localparam int F_SRC_ATTR  = 0;
    localparam int F_SRC       = 1;
    localparam int F_DST_ATTR  = 2;
    localparam int F_DST       = 3;
    localparam int F_LINK      = 5;
    localparam int F_COUNT     = 7;

    // link word flag positions
    localparam int LK_END      = 0;
    localparam int LK_SEG_IE   = 3;

    // register indices
    localparam int RG_MODE     = 0;
    localparam int RG_STAT     = 1;
    localparam int RG_CUR      = 2;
    localparam int RG_NEXT     = 3;
    localparam int RG_REMAIN   = 4;
    localparam int RG_SATTR    = 5;
    localparam int RG_DATTR    = 6;

    // mode bits
    localparam int MD_START    = 0;
    localparam int MD_ABORT    = 1;
    localparam int MD_ERR_IE   = 4;
    localparam int MD_SEG_IE   = 5;
    localparam int MD_END_IE   = 6;

    // status bits
    localparam int ST_BUSY     = 0;
    localparam int ST_HALT     = 1;
    localparam int ST_SEG      = 2;
    localparam int ST_END      = 3;
    localparam int ST_PERR     = 4;
    localparam int ST_TERR     = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_RD,
        S_WR,
        S_LINK
    } seq_state_e;

endpackage

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              abort_req,
    input  logic              cur_we,
    input  logic [WORD_W-1:0] cur_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              busy,
    output logic              ev_seg,
    output logic              ev_end,
    output logic              ev_perr,
    output logic              ev_terr,
    output logic              ev_stop,
    output logic [WORD_W-1:0] cur,
    output logic [WORD_W-1:0] nxt,
    output logic [WORD_W-1:0] remain,
    output logic [WORD_W-1:0] sattr,
    output logic [WORD_W-1:0] dattr
);

    localparam logic [WORD_W-1:0] ALIGN_MASK = ~((WORD_W'(1) << ALIGN_BITS) - 1);
    localparam logic [WORD_W-1:0] CNT_MASK   = ~((WORD_W'(1) << BYTE_SHIFT) - 1);
    localparam logic [WORD_W-1:0] STEP       = WORD_W'(1) << BYTE_SHIFT;

    typedef struct packed {
        seq_state_e            state;
        logic [DESC_IDX_W-1:0] widx;
        logic [WORD_W-1:0]     cur;
        logic [WORD_W-1:0]     nxt;
        logic [WORD_W-1:0]     src;
        logic [WORD_W-1:0]     dst;
        logic [WORD_W-1:0]     sattr;
        logic [WORD_W-1:0]     dattr;
        logic [WORD_W-1:0]     cnt;
        logic [WORD_W-1:0]     remain;
        logic [WORD_W-1:0]     data;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        ev_seg  = 1'b0;
        ev_end  = 1'b0;
        ev_perr = 1'b0;
        ev_terr = 1'b0;
        ev_stop = 1'b0;

        mem_req   = (q.state == S_FETCH) || (q.state == S_RD) || (q.state == S_WR);
        mem_we    = (q.state == S_WR);
        mem_wdata = q.data;
        case (q.state)
            S_RD:    mem_addr = q.src;
            S_WR:    mem_addr = q.dst;
            default: mem_addr = q.cur + (WORD_W'(q.widx) << BYTE_SHIFT);
        endcase

        case (q.state)
            S_IDLE: begin
                if (cur_we) d.cur = cur_wdata & ALIGN_MASK;
                if (go) begin
                    d.state = S_FETCH;
                    d.widx  = '0;
                end
            end
            S_FETCH: begin
                if (mem_ack) begin
                    case (q.widx)
                        DESC_IDX_W'(F_SRC_ATTR): d.sattr = mem_rdata;
                        DESC_IDX_W'(F_SRC):      d.src   = mem_rdata;
                        DESC_IDX_W'(F_DST_ATTR): d.dattr = mem_rdata;
                        DESC_IDX_W'(F_DST):      d.dst   = mem_rdata;
                        DESC_IDX_W'(F_LINK):     d.nxt   = mem_rdata;
                        DESC_IDX_W'(F_COUNT):    d.cnt   = mem_rdata;
                        default: ;
                    endcase
                    if (q.widx == DESC_IDX_W'(DESC_WORDS - 1)) d.state = S_CHECK;
                    else d.widx = q.widx + 1'b1;
                end
            end
            S_CHECK: begin
                if ((q.cnt & CNT_MASK) == '0) begin
                    d.remain = '0;
                    d.state  = S_IDLE;
                    ev_perr  = 1'b1;
                    ev_stop  = 1'b1;
                end else begin
                    d.remain = q.cnt & CNT_MASK;
                    d.state  = S_RD;
                end
            end
            S_RD: begin
                if (mem_ack) begin
                    d.data  = mem_rdata;
                    d.state = S_WR;
                end
            end
            S_WR: begin
                if (mem_ack) begin
                    d.src    = q.src + STEP;
                    d.dst    = q.dst + STEP;
                    d.remain = q.remain - STEP;
                    d.state  = (q.remain == STEP) ? S_LINK : S_RD;
                end
            end
            S_LINK: begin
                ev_seg = q.nxt[LK_SEG_IE];
                if (q.nxt[LK_END]) begin
                    ev_end  = 1'b1;
                    ev_stop = 1'b1;
                    d.state = S_IDLE;
                end else begin
                    d.cur   = q.nxt & ALIGN_MASK;
                    d.widx  = '0;
                    d.state = S_FETCH;
                end
            end
            default: d.state = S_IDLE;
        endcase

        if (mem_req && mem_ack && mem_err) begin
            d       = q;
            d.state = S_IDLE;
            ev_seg  = 1'b0;
            ev_end  = 1'b0;
            ev_perr = 1'b0;
            ev_terr = 1'b1;
            ev_stop = 1'b1;
        end else if (abort_req && (q.state != S_IDLE) && (!mem_req || mem_ack)) begin
            d.state = S_IDLE;
            ev_seg  = 1'b0;
            ev_end  = 1'b0;
            ev_perr = 1'b0;
            ev_stop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.state != S_IDLE);
    assign cur    = q.cur;
    assign nxt    = q.nxt;
    assign remain = q.remain;
    assign sattr  = q.sattr;
    assign dattr  = q.dattr;

    // R13: an open request holds its address, direction and data until acknowledged
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R7: a programming error leaves the count at zero and the channel idle
    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        ev_perr |=> (remain == '0) && !busy);

    // R12: the descriptor pointer in use is always 32-byte aligned
    a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur[ALIGN_BITS-1:0] == '0));

    // R9: abort with no open request stops the channel on the next edge
    a_r9_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req && busy && !mem_req |=> !busy && !mem_req);

endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              ev_seg,
    input  logic              ev_end,
    input  logic              ev_perr,
    input  logic              ev_terr,
    input  logic              ev_stop,
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] nxt,
    input  logic [WORD_W-1:0] remain,
    input  logic [WORD_W-1:0] sattr,
    input  logic [WORD_W-1:0] dattr,
    output logic              go,
    output logic              abort_req,
    output logic              cur_we,
    output logic              irq
);

    typedef struct packed {
        logic start;
        logic abort;
        logic err_ie;
        logic seg_ie;
        logic end_ie;
        logic halted;
        logic seg;
        logic fin;
        logic perr;
        logic terr;
    } ctl_t;

    ctl_t q, d;

    logic wr_mode, wr_stat;
    logic [WORD_W-1:0] mode_word, stat_word;

    always_comb begin
        wr_mode = reg_we && (reg_addr == REG_AW'(RG_MODE));
        wr_stat = reg_we && (reg_addr == REG_AW'(RG_STAT));
        cur_we  = reg_we && (reg_addr == REG_AW'(RG_CUR));
        go      = wr_mode && reg_wdata[MD_START] && !reg_wdata[MD_ABORT] && !busy;

        d = q;
        if (wr_mode) begin
            d.err_ie = reg_wdata[MD_ERR_IE];
            d.seg_ie = reg_wdata[MD_SEG_IE];
            d.end_ie = reg_wdata[MD_END_IE];
            if (busy) d.abort = q.abort | reg_wdata[MD_ABORT];
        end
        if (go) begin
            d.start  = 1'b1;
            d.halted = 1'b0;
        end
        if (wr_stat) begin
            if (reg_wdata[ST_SEG])  d.seg  = 1'b0;
            if (reg_wdata[ST_END])  d.fin  = 1'b0;
            if (reg_wdata[ST_PERR]) d.perr = 1'b0;
            if (reg_wdata[ST_TERR]) d.terr = 1'b0;
        end
        if (ev_seg)  d.seg  = 1'b1;
        if (ev_end)  d.fin  = 1'b1;
        if (ev_perr) d.perr = 1'b1;
        if (ev_terr) d.terr = 1'b1;
        if (ev_stop) begin
            d.halted = 1'b1;
            d.start  = 1'b0;
            d.abort  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mode_word = '0;
        mode_word[MD_START]  = q.start;
        mode_word[MD_ABORT]  = q.abort;
        mode_word[MD_ERR_IE] = q.err_ie;
        mode_word[MD_SEG_IE] = q.seg_ie;
        mode_word[MD_END_IE] = q.end_ie;
        stat_word = '0;
        stat_word[ST_BUSY] = busy;
        stat_word[ST_HALT] = q.halted;
        stat_word[ST_SEG]  = q.seg;
        stat_word[ST_END]  = q.fin;
        stat_word[ST_PERR] = q.perr;
        stat_word[ST_TERR] = q.terr;
        case (reg_addr)
            REG_AW'(RG_MODE):   reg_rdata = mode_word;
            REG_AW'(RG_STAT):   reg_rdata = stat_word;
            REG_AW'(RG_CUR):    reg_rdata = cur;
            REG_AW'(RG_NEXT):   reg_rdata = nxt;
            REG_AW'(RG_REMAIN): reg_rdata = remain;
            REG_AW'(RG_SATTR):  reg_rdata = sattr;
            REG_AW'(RG_DATTR):  reg_rdata = dattr;
            default:            reg_rdata = '0;
        endcase
    end

    assign abort_req = q.abort;
    assign irq = (q.err_ie & (q.perr | q.terr)) | (q.seg_ie & q.seg) | (q.end_ie & q.fin);

    // R6: every stop leaves the channel halted with start released
    a_r6_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> q.halted && !q.start && !q.abort);

    // R2: a start clears halted
    a_r2_go_clears_halt: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !q.halted && q.start);

    // R10: a one written to the segment bit clears it unless a new event arrives
    a_r10_w1c_seg: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && reg_wdata[ST_SEG] && !ev_seg |=> !q.seg);

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              irq
);

    logic go, abort_req, cur_we, busy;
    logic ev_seg, ev_end, ev_perr, ev_terr, ev_stop;
    logic [WORD_W-1:0] cur, nxt, remain, sattr, dattr;

    dma_chain_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .abort_req (abort_req),
        .cur_we    (cur_we),
        .cur_wdata (reg_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .busy      (busy),
        .ev_seg    (ev_seg),
        .ev_end    (ev_end),
        .ev_perr   (ev_perr),
        .ev_terr   (ev_terr),
        .ev_stop   (ev_stop),
        .cur       (cur),
        .nxt       (nxt),
        .remain    (remain),
        .sattr     (sattr),
        .dattr     (dattr)
    );

    dma_chain_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .ev_seg    (ev_seg),
        .ev_end    (ev_end),
        .ev_perr   (ev_perr),
        .ev_terr   (ev_terr),
        .ev_stop   (ev_stop),
        .cur       (cur),
        .nxt       (nxt),
        .remain    (remain),
        .sattr     (sattr),
        .dattr     (dattr),
        .go        (go),
        .abort_req (abort_req),
        .cur_we    (cur_we),
        .irq       (irq)
    );

    // R11: the interrupt only rises together with, or after, a sticky event
    a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_seg || ev_end || ev_perr || ev_terr || reg_we));

endmodule

// File: tb/tb_dma_chain_ctrl.sv
module tb_dma_chain_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    dma_chain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    // memory model: random 0..2 cycle stall, backdoor port for setup
    logic [31:0] mem [0:1023];
    logic [31:0] rd_log [0:63];
    int          rd_total = 0;
    int          wr_total = 0;
    int          wait_cnt = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic        bd_we = 1'b0;
    logic [9:0]  bd_idx = '0;
    logic [31:0] bd_data = '0;

    always @(negedge clk) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
        if (bd_we) mem[bd_idx] = bd_data;
        if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ack = 1'b1;
                mem_err = (mem_addr == err_addr);
                if (mem_we) begin
                    if (!mem_err) begin
                        mem[mem_addr[11:2]] = mem_wdata;
                        wr_total++;
                    end
                end else begin
                    mem_rdata = mem[mem_addr[11:2]];
                    rd_log[rd_total % 64] = mem_addr;
                    rd_total++;
                end
                wait_cnt = $urandom % 3;
            end else begin
                wait_cnt--;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    task automatic poke(input logic [31:0] byte_addr, input logic [31:0] val);
        bd_we = 1'b1; bd_idx = byte_addr[11:2]; bd_data = val;
        @(negedge clk); #1;
        bd_we = 1'b0;
    endtask

    task automatic rwr(input int idx, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(idx); reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rrd(input int idx, output logic [31:0] val);
        @(negedge clk);
        reg_addr = 3'(idx);
        #1 val = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rrd(1, s);
            if (!s[0]) break;
        end
    endtask

    function automatic logic [31:0] exp_irq(input logic [31:0] mode, input logic [31:0] st);
        return {31'b0, (mode[4] & (st[4] | st[5])) | (mode[5] & st[2]) | (mode[6] & st[3])};
    endfunction

    task automatic write_desc(input logic [31:0] base, input logic [31:0] sa, input logic [31:0] src,
                              input logic [31:0] da, input logic [31:0] dst,
                              input logic [31:0] link, input logic [31:0] cnt);
        poke(base + 0,  sa);
        poke(base + 4,  src);
        poke(base + 8,  da);
        poke(base + 12, dst);
        poke(base + 16, $urandom);
        poke(base + 20, link);
        poke(base + 24, $urandom);
        poke(base + 28, cnt);
    endtask

    task automatic run_chain(input int run);
        int nseg, total, mism, rd0;
        logic [31:0] link, sa, da, mode, v, seg_any, last_link;
        nseg = 1 + $urandom % 5;
        total = 0;
        seg_any = 0;
        for (int i = 0; i < nseg; i++) begin
            int nw;
            nw = 1 + $urandom % 6;
            sa = $urandom;
            da = $urandom;
            link = (i == nseg - 1) ? 32'h0 : 32'((i + 1) * 32);
            if (i == nseg - 1) link[0] = 1'b1;
            if ($urandom % 2) begin link[3] = 1'b1; seg_any = 1; end
            if (i != nseg - 1) link[2:1] = 2'($urandom);
            for (int k = 0; k < nw; k++) begin
                poke(32'h400 + 32'((total + k) * 4), $urandom | 32'h1);
                poke(32'h800 + 32'((total + k) * 4), 32'h0);
            end
            poke(32'h800 + 32'((total + nw) * 4), 32'h0);
            write_desc(32'(i * 32), sa, 32'h400 + 32'(total * 4), da, 32'h800 + 32'(total * 4),
                       link, 32'(nw * 4) + 32'($urandom % 4));
            total += nw;
            last_link = link;
        end
        rwr(2, 32'h0);
        mode = {25'b0, 3'($urandom), 4'b0001};
        rd0 = rd_total;
        rwr(0, mode);
        wait_idle();
        // R2: fetch order of first descriptor
        mism = 0;
        for (int k = 0; k < 8; k++) if (rd_log[(rd0 + k) % 64] != 32'(k * 4)) mism++;
        chk($sformatf("R2 fetch order run%0d", run), 32'(mism), 0);
        // R6 R5: final status
        rrd(1, v);
        chk($sformatf("R6 R5 status run%0d", run), v, 32'h0A | (seg_any << 2));
        chk($sformatf("R11 irq run%0d", run), {31'b0, irq}, exp_irq(mode, v));
        rrd(0, v);
        chk($sformatf("R6 start cleared run%0d", run), v, mode & 32'h70);
        rrd(2, v);
        chk($sformatf("R5 R6 cur run%0d", run), v, 32'((nseg - 1) * 32));
        rrd(3, v);
        chk($sformatf("R5 next word run%0d", run), v, last_link);
        rrd(4, v);
        chk($sformatf("R4 remain run%0d", run), v, 0);
        rrd(5, v);
        chk($sformatf("R3 src attr run%0d", run), v, sa);
        rrd(6, v);
        chk($sformatf("R3 dst attr run%0d", run), v, da);
        // R4: payload copied exactly, no overrun
        mism = 0;
        for (int k = 0; k < total; k++) if (mem[10'(512 + k)] !== mem[10'(256 + k)]) mism++;
        chk($sformatf("R4 R3 copy data run%0d", run), 32'(mism), 0);
        chk($sformatf("R4 no overrun run%0d", run), mem[10'(512 + total)], 0);
        rwr(1, 32'h3C);
        rrd(1, v);
        chk($sformatf("R10 clear run%0d", run), v, 32'h2);
    endtask

    initial begin
        logic [31:0] v;
        int w0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        rrd(0, v); chk("R1 mode", v, 0);
        rrd(1, v); chk("R1 status", v, 0);
        rrd(2, v); chk("R1 cur", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 mem_req", {31'b0, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: unaligned write is masked
        rwr(2, 32'h7F);
        rrd(2, v); chk("R12 cur align", v, 32'h60);

        for (int r = 0; r < 6; r++) run_chain(r);

        // R7: zero-length descriptor
        write_desc(32'h200, 0, 32'h400, 0, 32'h800, 32'h1, 32'h3);
        rwr(2, 32'h200);
        w0 = wr_total;
        rwr(0, 32'h11);
        wait_idle();
        rrd(1, v); chk("R7 perr status", v, 32'h12);
        rrd(4, v); chk("R7 remain zero", v, 0);
        chk("R7 no payload write", 32'(wr_total - w0), 0);
        chk("R11 irq on perr", {31'b0, irq}, 1);
        rwr(1, 32'h0);
        rrd(1, v); chk("R10 zero write keeps", v, 32'h12);
        rwr(1, 32'h13);
        rrd(1, v); chk("R10 w1c and busy/halt ro", v, 32'h2);
        chk("R11 irq cleared", {31'b0, irq}, 0);

        // R8: bus error on third source read
        write_desc(32'h240, 0, 32'h500, 0, 32'h900, 32'h1, 32'h10);
        err_addr = 32'h508;
        rwr(2, 32'h240);
        w0 = wr_total;
        rwr(0, 32'h11);
        wait_idle();
        err_addr = 32'hFFFF_FFFF;
        rrd(1, v); chk("R8 terr status", v, 32'h22);
        chk("R8 writes before error", 32'(wr_total - w0), 2);
        chk("R11 irq on terr", {31'b0, irq}, 1);
        rwr(1, 32'h3C);

        // R9 R12: abort a long copy
        write_desc(32'h100, 0, 32'h400, 0, 32'h800, 32'h9, 32'hF0);
        rwr(2, 32'h100);
        rwr(0, 32'h61);
        repeat (30) @(negedge clk);
        rwr(2, 32'h40);
        rrd(2, v); chk("R12 cur write ignored busy", v, 32'h100);
        rwr(0, 32'h62);
        repeat (8) @(negedge clk);
        rrd(1, v); chk("R9 abort status", v, 32'h2);
        rrd(0, v); chk("R9 mode bits cleared", v, 32'h60);
        chk("R9 no irq after abort", {31'b0, irq}, 0);
        w0 = wr_total;
        repeat (20) @(negedge clk);
        chk("R9 quiet after abort", 32'(wr_total - w0), 0);
        chk("R9 no request", {31'b0, mem_req}, 0);
        rrd(4, v); chk("R9 stopped early", {31'b0, v != 0}, 1);

        summary();
    end

endmodule